// File: doc/BRIEF.md
# DRAM Bank Strobe Decoder

This block sits between a memory controller's row and column strobes and four DRAM banks. It takes the top four bits of a 20-bit byte address (the 64K page number) and decides which bank, if any, receives the strobes. It also asserts a shared active-low enable for the one bidirectional data buffer in front of all banks, and it sets that buffer's direction.

Two memory maps are built in. In the quad map, four equal 64K banks fill the first 256K of the address space. In the wide map, banks 0 and 1 each cover a full 256K page, and banks 2 and 3 each cover a single 64K block just above 512K. Together they fill the space up to 640K. The map is chosen by a strap pin. The strap is captured only while reset is held, so a change on it during operation does nothing. A refresh request drives the row strobe into every bank at once and keeps the column strobes and the buffer quiet.

The block carries no data stream. Every pin is a plain level control, so there is no valid/ready handshake and no back-pressure.

Top module: `dram_bank_select`

## Requirements
- R1: With the quad map captured (strap 0), page values 0, 1, 2 and 3 (addr_hi_i) select banks 0, 1, 2 and 3 respectively. Page values 4 to 15 select no bank.
- R2: With the wide map captured (strap 1), page values 0 to 3 select bank 0 and page values 4 to 7 select bank 1.
- R3: With the wide map captured, page 8 selects bank 2 and page 9 selects bank 3. Pages 10 to 15 select no bank, and all strobe outputs then stay high.
- R4: At most one bank is selected at a time. Outside refresh, buf_en_n_o is low exactly when a bank is selected.
- R5: Outside refresh, the selected bank's bank_ras_n_o[b] equals ras_strobe_n_i and its bank_cas_n_o[b] equals cas_strobe_n_i. Every other bank holds both outputs high.
- R6: While refresh_i is 1, every bank_ras_n_o bit equals ras_strobe_n_i whatever the address. Every bank_cas_n_o bit stays high and buf_en_n_o stays high.
- R7: The strap is sampled on clock edges only while rst_n is low. A strap change after reset is released leaves the decode unchanged until the next reset.
- R8: buf_dir_o is 1 (toward the bus) when write_i is 0 and 0 (toward the DRAM) when write_i is 1.
- R9: While rst_n is low, all strobe outputs and buf_en_n_o are high, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the strap capture register |
| rst_n | input | 1 | Active-low synchronous reset; the strap is captured while it is low |
| map_strap_i | input | 1 | Map choice: 0 quad 64K map, 1 wide 640K map |
| addr_hi_i | input | 4 | Address bits 19..16 (64K page number) |
| ras_strobe_n_i | input | 1 | Incoming active-low row strobe |
| cas_strobe_n_i | input | 1 | Incoming active-low column strobe |
| refresh_i | input | 1 | Refresh request, active high |
| write_i | input | 1 | Cycle direction: 1 write, 0 read |
| bank_ras_n_o | output | 4 | Per-bank active-low row strobes |
| bank_cas_n_o | output | 4 | Per-bank active-low column strobes |
| buf_en_n_o | output | 1 | Active-low enable of the shared data buffer |
| buf_dir_o | output | 1 | Buffer direction: 1 toward bus, 0 toward DRAM |

## Verification
The hardest case to reach is a strap that disagrees with the captured map. The decode only reveals which map is in force through which bank answers on a page where the two maps differ. The stimulus therefore resets in the quad map and then flips the strap while running. It probes pages 4 and 8, where the wide map would select a bank and the quad map selects none. A second reset then shows the new strap taking effect. Refresh is driven on an unmapped page with the column strobe low, which separates the override from ordinary decode.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
  localparam int unsigned PAGE_W    = 4;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_IDX_W = $clog2(NUM_BANKS);

  typedef enum logic {
    MAP_QUAD = 1'b0,
    MAP_WIDE = 1'b1
  } map_e;

  typedef logic [NUM_BANKS-1:0] bank_vec_t;
  typedef logic [PAGE_W-1:0]    page_t;

  // Returns 1 when page pg belongs to bank idx under map m.
  function automatic logic bank_hit(input map_e m, input page_t pg,
                                    input logic [BANK_IDX_W-1:0] idx);
    logic hit;
    hit = 1'b0;
    if (m == MAP_QUAD) begin
      hit = (pg[3:2] == 2'b00) && (pg[1:0] == idx);
    end else if (idx[1] == 1'b0) begin
      hit = (pg[3:2] == {1'b0, idx[0]});
    end else begin
      hit = (pg[3:1] == 3'b100) && (pg[0] == idx[0]);
    end
    return hit;
  endfunction
endpackage

// File: rtl/map_mode_latch.sv
module map_mode_latch
  import bank_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output map_e mode_o
);
  map_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= map_e'(strap_i);
  end

  assign mode_o = mode_q;

  // R7: captured map never moves once reset has been released
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/bank_page_decode.sv
module bank_page_decode
  import bank_sel_pkg::*;
(
  input  map_e      mode_i,
  input  page_t     page_i,
  output bank_vec_t hit_o,
  output logic      ram_sel_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    localparam logic [BANK_IDX_W-1:0] IDX = BANK_IDX_W'(b);
    assign hit_o[b] = bank_hit(mode_i, page_i, IDX);
  end

  assign ram_sel_o = |hit_o;
endmodule

// File: rtl/bank_strobe_gate.sv
module bank_strobe_gate (
  input  logic run_i,
  input  logic hit_i,
  input  logic refresh_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  output logic ras_n_o,
  output logic cas_n_o
);
  always_comb begin
    ras_n_o = ~(run_i & ~ras_n_i & (refresh_i | hit_i));
    cas_n_o = ~(run_i & ~cas_n_i & hit_i & ~refresh_i);
  end
endmodule

// File: rtl/dram_bank_select.sv
module dram_bank_select
  import bank_sel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 map_strap_i,
  input  logic [PAGE_W-1:0]    addr_hi_i,
  input  logic                 ras_strobe_n_i,
  input  logic                 cas_strobe_n_i,
  input  logic                 refresh_i,
  input  logic                 write_i,
  output logic [NUM_BANKS-1:0] bank_ras_n_o,
  output logic [NUM_BANKS-1:0] bank_cas_n_o,
  output logic                 buf_en_n_o,
  output logic                 buf_dir_o
);
  map_e      mode;
  bank_vec_t hit;
  logic      ram_sel;

  map_mode_latch i_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (map_strap_i),
    .mode_o  (mode)
  );

  bank_page_decode i_dec (
    .mode_i    (mode),
    .page_i    (addr_hi_i),
    .hit_o     (hit),
    .ram_sel_o (ram_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_strobe_gate i_gate (
      .run_i     (rst_n),
      .hit_i     (hit[b]),
      .refresh_i (refresh_i),
      .ras_n_i   (ras_strobe_n_i),
      .cas_n_i   (cas_strobe_n_i),
      .ras_n_o   (bank_ras_n_o[b]),
      .cas_n_o   (bank_cas_n_o[b])
    );
  end

  assign buf_en_n_o = ~(rst_n & ram_sel & ~refresh_i);
  assign buf_dir_o  = ~write_i;

  // R4: no two banks strobed together
  p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bank_cas_n_o) <= 1);
  // R4: a column strobe reaches a bank only with the buffer enabled
  p_cas_has_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_cas_n_o != '1) |-> !buf_en_n_o);
  // R6: refresh keeps column strobes and buffer idle
  p_refresh_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_i |-> ((bank_cas_n_o == '1) && buf_en_n_o));
  // R6: refresh copies the row strobe into every bank
  p_refresh_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_i |-> (bank_ras_n_o == {NUM_BANKS{ras_strobe_n_i}}));
  // R3: pages above the wide map's top stay silent
  p_above_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MAP_WIDE && addr_hi_i >= 4'd10 && !refresh_i) |->
      ((bank_ras_n_o == '1) && (bank_cas_n_o == '1) && buf_en_n_o));
  // R8: direction follows the cycle type while the buffer is on
  p_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en_n_o |-> (buf_dir_o != write_i));
  // R9: everything idle while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r9: assert ((bank_ras_n_o == '1) && (bank_cas_n_o == '1) && buf_en_n_o);
    end
  end
endmodule

// File: tb/test_dram_bank_select.sv
module test_dram_bank_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic [3:0] addr = 4'd0;
  logic       ras_n = 1'b1;
  logic       cas_n = 1'b1;
  logic       refresh = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] bras_n, bcas_n;
  logic       ben_n, bdir;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  dram_bank_select i_dram_bank_select (
    .clk(clk), .rst_n(rst_n), .map_strap_i(strap), .addr_hi_i(addr),
    .ras_strobe_n_i(ras_n), .cas_strobe_n_i(cas_n), .refresh_i(refresh),
    .write_i(wr), .bank_ras_n_o(bras_n), .bank_cas_n_o(bcas_n),
    .buf_en_n_o(ben_n), .buf_dir_o(bdir)
  );

  // {strap, page, expected one-hot bank}
  localparam logic [8:0] VEC [32] = '{
    {1'b0,4'd0,4'b0001}, {1'b0,4'd1,4'b0010}, {1'b0,4'd2,4'b0100}, {1'b0,4'd3,4'b1000},
    {1'b0,4'd4,4'b0000}, {1'b0,4'd5,4'b0000}, {1'b0,4'd6,4'b0000}, {1'b0,4'd7,4'b0000},
    {1'b0,4'd8,4'b0000}, {1'b0,4'd9,4'b0000}, {1'b0,4'd10,4'b0000},{1'b0,4'd11,4'b0000},
    {1'b0,4'd12,4'b0000},{1'b0,4'd13,4'b0000},{1'b0,4'd14,4'b0000},{1'b0,4'd15,4'b0000},
    {1'b1,4'd0,4'b0001}, {1'b1,4'd1,4'b0001}, {1'b1,4'd2,4'b0001}, {1'b1,4'd3,4'b0001},
    {1'b1,4'd4,4'b0010}, {1'b1,4'd5,4'b0010}, {1'b1,4'd6,4'b0010}, {1'b1,4'd7,4'b0010},
    {1'b1,4'd8,4'b0100}, {1'b1,4'd9,4'b1000}, {1'b1,4'd10,4'b0000},{1'b1,4'd11,4'b0000},
    {1'b1,4'd12,4'b0000},{1'b1,4'd13,4'b0000},{1'b1,4'd14,4'b0000},{1'b1,4'd15,4'b0000}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic apply(input logic [3:0] a, input logic r, input logic c, input logic f);
    @(negedge clk);
    addr = a; ras_n = r; cas_n = c; refresh = f;
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: idle during reset even with both strobes low on a mapped page
    @(negedge clk);
    ras_n = 1'b0; cas_n = 1'b0; addr = 4'd0;
    repeat (2) @(posedge clk);
    #2;
    chk("R9 reset ras", {4'h0, bras_n}, 8'h0F);
    chk("R9 reset cas/en", {3'b0, ben_n, bcas_n}, 8'h1F);

    // R1 R2 R3 R4 R5: table sweep of both maps
    for (int i = 0; i < 32; i++) begin
      logic [3:0] e;
      e = VEC[i][3:0];
      if (i == 0 || i == 16) do_reset(VEC[i][8]);
      apply(VEC[i][7:4], 1'b0, 1'b1, 1'b0);
      chk(VEC[i][8] ? "R2/R3 ras map" : "R1 ras map", {4'h0, bras_n}, {4'h0, ~e});
      chk("R4 buf enable", {7'b0, ben_n}, {7'b0, (e == 4'b0)});
      chk("R5 cas idle under ras", {4'h0, bcas_n}, 8'h0F);
      apply(VEC[i][7:4], 1'b0, 1'b0, 1'b0);
      chk("R5 cas follows", {4'h0, bcas_n}, {4'h0, ~e});
      chk("R4 at most one", 8'($countones(~bcas_n)), 8'($countones(e)));
    end

    // R5: strobes inactive leave the selected bank high
    apply(4'd9, 1'b1, 1'b1, 1'b0);
    chk("R5 inactive strobes", {bras_n, bcas_n}, 8'hFF);

    // R6: refresh on an unmapped page with CAS low
    apply(4'd15, 1'b0, 1'b0, 1'b1);
    chk("R6 refresh ras all", {4'h0, bras_n}, 8'h00);
    chk("R6 refresh cas/en", {3'b0, ben_n, bcas_n}, 8'h1F);
    apply(4'd8, 1'b1, 1'b0, 1'b1);
    chk("R6 refresh ras follows high", {4'h0, bras_n}, 8'h0F);
    chk("R6 refresh mapped cas/en", {3'b0, ben_n, bcas_n}, 8'h1F);

    // R8: buffer direction
    apply(4'd0, 1'b0, 1'b0, 1'b0);
    wr = 1'b0; #1;
    chk("R8 read dir", {7'b0, bdir}, 8'h01);
    wr = 1'b1; #1;
    chk("R8 write dir", {7'b0, bdir}, 8'h00);
    wr = 1'b0;

    // R7: strap change while running is ignored until the next reset
    do_reset(1'b0);
    @(negedge clk);
    strap = 1'b1;
    repeat (3) @(posedge clk);
    apply(4'd4, 1'b0, 1'b1, 1'b0);
    chk("R7 page 4 still quad", {3'b0, ben_n, bras_n}, 8'h1F);
    apply(4'd8, 1'b0, 1'b1, 1'b0);
    chk("R7 page 8 still quad", {3'b0, ben_n, bras_n}, 8'h1F);
    do_reset(1'b1);
    apply(4'd8, 1'b0, 1'b1, 1'b0);
    chk("R7 wide after reset", {3'b0, ben_n, bras_n}, 8'h0B);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule